// File: doc/BRIEF.md
# Latched SRAM Host Controller

This block sits on the host side of an asynchronous 16-bit static RAM that can capture its address and chip select internally. It takes one read or write request at a time and turns it into a timed sequence on the memory pins. First it presents the address with chip select low while the address-latch strobe is high, so the memory's latch is transparent. Then it drops the latch strobe so the memory captures the address, and it keeps the address on the bus for a short hold. After that it releases both the address bus and the external chip select. The memory keeps working from its latched copy while the controller pulses the write or output-enable strobe. Each access ends with a recovery phase in which the latch strobe and chip select both return high.

Requests arrive on a valid/ready port. `req_ready` is high only when the controller is idle and no read response is waiting. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Read data leaves on a valid/ready port. `rsp_valid` stays high and `rsp_rdata` stays unchanged until the consumer raises `rsp_ready`. While a response waits, no new request is accepted. Writes produce no response.

The length of each phase is set by a parameter counted in clock cycles, with a minimum of 1: setup `T_SETUP`, latch hold `T_HOLD`, strobe `T_STROBE` and recovery `T_RECOV`. The data bus is split into `mem_dq_out`, `mem_dq_oe` and `mem_dq_in`, to be joined at a tri-state pad.

Top module: `lsram_host_ctrl`

## Requirements
- R1: After reset the following hold: `mem_ale_n`, `mem_cs_n`, `mem_we_n`, `mem_oe_n` and every bit of `mem_be_n` are high, `mem_dq_oe` is low, `mem_addr` is zero, `req_ready` is high and `rsp_valid` is low.
- R2: After a request is accepted, the controller spends `T_SETUP` cycles with `mem_cs_n` low, `mem_ale_n` high and `mem_addr` equal to the request address. It then spends `T_HOLD` cycles with `mem_ale_n` low, `mem_cs_n` low and the address still driven.
- R3: For the rest of the access (strobe and recovery), `mem_addr` is driven to zero and `mem_cs_n` is high. The address the memory latched on the falling edge of `mem_ale_n` equals the request address.
- R4: A write holds `mem_we_n` low for exactly `T_STROBE` cycles while `mem_ale_n` is low. During exactly those cycles `mem_dq_oe` is high and `mem_dq_out` carries the write data. `mem_oe_n` stays high for the whole write.
- R5: A read holds `mem_oe_n` low for exactly `T_STROBE` cycles while `mem_ale_n` is low, with `mem_we_n` high. `rsp_valid` first appears `T_SETUP+T_HOLD+T_STROBE` cycles after the accepting edge, carrying the bus value present in the last strobe cycle.
- R6: Byte lanes are active low during the strobe phase: `mem_be_n[0]` (low byte, bits 7:0) is the inverse of `req_be[0]`, and `mem_be_n[1]` (bits 15:8) is the inverse of `req_be[1]`. Outside the strobe phase all `mem_be_n` bits are high. In `rsp_rdata`, a lane that was not enabled reads as zero.
- R7: After the strobe, `mem_ale_n`, `mem_cs_n` and all strobes are high for `T_RECOV` cycles before `req_ready` returns. A write therefore sees `req_ready` again `T_SETUP+T_HOLD+T_STROBE+T_RECOV` cycles after acceptance.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high, `rsp_rdata` does not change and `req_ready` stays low.
- R9: `mem_dq_oe` is never high while `mem_oe_n` is low, and `mem_we_n` and `mem_oe_n` are never low together, so the data bus never has two drivers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (18) | Word address |
| req_wdata | input | DW (16) | Write data |
| req_be | input | DW/8 (2) | Byte enables, active high, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | DW (16) | Read data, disabled lanes zero |
| mem_addr | output | AW (18) | Memory address bus, zero when released |
| mem_ale_n | output | 1 | Address latch enable, low = latched |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | DW/8 (2) | Byte lane selects, active low, bit 0 = low byte |
| mem_dq_out | output | DW (16) | Data to memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | DW (16) | Data from the bus |

## Verification
The bench uses a memory model that really latches the address and chip select while `mem_ale_n` is low. A design that drops the address before the latch edge, or too early, makes the model record a wrong latched address, and any corruption appears in later read-back. Lanes the model does not drive come back as a fixed junk pattern, so a design that fails to mask disabled bytes returns nonzero lanes. Phase lengths are deliberately set to different values and every phase is counted, which exposes a design that swaps or miscounts a phase. Random back-pressure on the response port catches a design that drops or changes pending read data, or that accepts a new request while a response waits.

// File: rtl/lsram_pkg.sv
package lsram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_HOLD   = 3'd2,
    PH_STROBE = 3'd3,
    PH_RECOV  = 3'd4
  } phase_t;

  function automatic int max_of4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/lsram_phase_timer.sv
module lsram_phase_timer
  import lsram_pkg::*;
#(
  parameter int T_SETUP  = 1,
  parameter int T_HOLD   = 1,
  parameter int T_STROBE = 2,
  parameter int T_RECOV  = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_t phase,
  output logic   strobe_done
);

  localparam int TMAX = max_of4(T_SETUP, T_HOLD, T_STROBE, T_RECOV);
  localparam int CW   = (TMAX < 2) ? 1 : $clog2(TMAX);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] span_of(phase_t p);
    case (p)
      PH_SETUP:  return CW'(T_SETUP - 1);
      PH_HOLD:   return CW'(T_HOLD - 1);
      PH_STROBE: return CW'(T_STROBE - 1);
      PH_RECOV:  return CW'(T_RECOV - 1);
      default:   return '0;
    endcase
  endfunction

  function automatic phase_t follow(phase_t p);
    case (p)
      PH_SETUP:  return PH_HOLD;
      PH_HOLD:   return PH_STROBE;
      PH_STROBE: return PH_RECOV;
      default:   return PH_IDLE;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (phase == PH_IDLE) begin
      if (start) begin
        phase <= PH_SETUP;
        cnt   <= span_of(PH_SETUP);
      end
    end else if (cnt == '0) begin
      phase <= follow(phase);
      cnt   <= span_of(follow(phase));
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign strobe_done = (phase == PH_STROBE) && (cnt == '0);

  AST_STROBE_TO_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_done |=> (phase == PH_RECOV)); // R7

  AST_START_TO_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && start) |=> (phase == PH_SETUP)); // R2

endmodule

// File: rtl/lsram_req_reg.sv
module lsram_req_reg #(
  parameter int AW = 18,
  parameter int DW = 16,
  parameter int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          in_write,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  input  logic [BW-1:0] in_be,
  output logic          r_write,
  output logic [AW-1:0] r_addr,
  output logic [DW-1:0] r_wdata,
  output logic [BW-1:0] r_be
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_write <= 1'b0;
      r_addr  <= '0;
      r_wdata <= '0;
      r_be    <= '0;
    end else if (load) begin
      r_write <= in_write;
      r_addr  <= in_addr;
      r_wdata <= in_wdata;
      r_be    <= in_be;
    end
  end

endmodule

// File: rtl/lsram_rsp_stage.sv
module lsram_rsp_stage #(
  parameter int DW = 16,
  parameter int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [BW-1:0] lane_en,
  input  logic [DW-1:0] bus_in,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  logic [DW-1:0] lane_mask;

  for (genvar g = 0; g < BW; g++) begin : g_mask
    assign lane_mask[g*8 +: 8] = {8{lane_en[g]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (capture) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= bus_in & lane_mask;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R8

endmodule

// File: rtl/lsram_host_ctrl.sv
module lsram_host_ctrl
  import lsram_pkg::*;
#(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int T_SETUP  = 1,
  parameter int T_HOLD   = 1,
  parameter int T_STROBE = 2,
  parameter int T_RECOV  = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW/8-1:0] req_be,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [DW-1:0]   rsp_rdata,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_ale_n,
  output logic            mem_cs_n,
  output logic            mem_we_n,
  output logic            mem_oe_n,
  output logic [DW/8-1:0] mem_be_n,
  output logic [DW-1:0]   mem_dq_out,
  output logic            mem_dq_oe,
  input  logic [DW-1:0]   mem_dq_in
);

  localparam int BW = DW / 8;

  phase_t        phase;
  logic          strobe_done;
  logic          accept;
  logic          r_write;
  logic [AW-1:0] r_addr;
  logic [DW-1:0] r_wdata;
  logic [BW-1:0] r_be;

  assign req_ready = (phase == PH_IDLE) && !rsp_valid;
  assign accept    = req_valid && req_ready;

  lsram_phase_timer #(
    .T_SETUP (T_SETUP),
    .T_HOLD  (T_HOLD),
    .T_STROBE(T_STROBE),
    .T_RECOV (T_RECOV)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .phase      (phase),
    .strobe_done(strobe_done)
  );

  lsram_req_reg #(.AW(AW), .DW(DW), .BW(BW)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .in_write(req_write),
    .in_addr (req_addr),
    .in_wdata(req_wdata),
    .in_be   (req_be),
    .r_write (r_write),
    .r_addr  (r_addr),
    .r_wdata (r_wdata),
    .r_be    (r_be)
  );

  lsram_rsp_stage #(.DW(DW), .BW(BW)) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (strobe_done && !r_write),
    .lane_en  (r_be),
    .bus_in   (mem_dq_in),
    .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  logic addr_phase;
  logic strobe_phase;

  assign addr_phase   = (phase == PH_SETUP) || (phase == PH_HOLD);
  assign strobe_phase = (phase == PH_STROBE);

  always_comb begin
    mem_addr   = addr_phase ? r_addr : '0;
    mem_cs_n   = !addr_phase;
    mem_ale_n  = !((phase == PH_HOLD) || strobe_phase);
    mem_we_n   = !(strobe_phase && r_write);
    mem_oe_n   = !(strobe_phase && !r_write);
    mem_be_n   = strobe_phase ? ~r_be : '1;
    mem_dq_oe  = strobe_phase && r_write;
    mem_dq_out = mem_dq_oe ? r_wdata : '0;
  end

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n)); // R9

  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n)); // R9

  AST_STROBE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> (!mem_ale_n && mem_cs_n && mem_addr == '0)); // R3

  AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R8

  AST_LATCH_HAS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ale_n) |-> !mem_cs_n); // R2

  AST_RECOV_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ale_n) |-> (mem_cs_n && mem_we_n && mem_oe_n)); // R7

endmodule

// File: tb/lsram_host_ctrl_tb.sv
module lsram_host_ctrl_tb;

  localparam int AW  = 18;
  localparam int DW  = 16;
  localparam int TS  = 2;
  localparam int TH  = 1;
  localparam int TST = 3;
  localparam int TR  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_be = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ale_n, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]    mem_be_n;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  lsram_host_ctrl #(
    .AW(AW), .DW(DW), .T_SETUP(TS), .T_HOLD(TH), .T_STROBE(TST), .T_RECOV(TR)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ale_n(mem_ale_n), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // ---------------- memory model with address/select latch ----------------
  logic [DW-1:0] mem_arr [logic [AW-1:0]];
  logic [DW-1:0] ref_arr [logic [AW-1:0]];
  logic [AW-1:0] lat_a = '0;
  logic          lat_cs_n = 1'b1;
  logic [AW-1:0] exp_addr = '0;
  bit            addr_err = 0;
  bit            fight_err = 0;

  always @(*) if (mem_ale_n) begin
    lat_a    = mem_addr;
    lat_cs_n = mem_cs_n;
  end

  function automatic logic [DW-1:0] model_word(logic [AW-1:0] a);
    return mem_arr.exists(a) ? mem_arr[a] : '0;
  endfunction

  always @(*) begin
    logic [DW-1:0] w;
    w = model_word(lat_a);
    for (int i = 0; i < 2; i++) begin
      if (mem_dq_oe) mem_dq_in[i*8 +: 8] = mem_dq_out[i*8 +: 8];
      else if (!lat_cs_n && mem_we_n && !mem_oe_n && !mem_be_n[i])
        mem_dq_in[i*8 +: 8] = w[i*8 +: 8];
      else mem_dq_in[i*8 +: 8] = 8'hA5;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (!lat_cs_n && (!mem_we_n || !mem_oe_n) && lat_a != exp_addr) addr_err = 1;
    if (mem_dq_oe && !lat_cs_n && mem_we_n && !mem_oe_n) fight_err = 1;
    if (!mem_we_n && !mem_oe_n) fight_err = 1;
    if (!lat_cs_n && !mem_we_n) begin
      logic [DW-1:0] w;
      w = model_word(lat_a);
      for (int i = 0; i < 2; i++)
        if (!mem_be_n[i]) w[i*8 +: 8] = mem_dq_out[i*8 +: 8];
      mem_arr[lat_a] = w;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_read(logic [AW-1:0] a, logic [1:0] be);
    logic [DW-1:0] w;
    w = ref_arr.exists(a) ? ref_arr[a] : '0;
    return w & {{8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic void ref_write(logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] be);
    logic [DW-1:0] w;
    w = ref_arr.exists(a) ? ref_arr[a] : '0;
    for (int i = 0; i < 2; i++) if (be[i]) w[i*8 +: 8] = d[i*8 +: 8];
    ref_arr[a] = w;
  endfunction

  task automatic run_txn(bit wr, logic [AW-1:0] a, logic [DW-1:0] wd,
                         logic [1:0] be, int bp);
    int n, n_setup, n_hold, n_strobe, n_rsp, n_hs, n_ready, hold_left, exp_ready;
    bit seen, rel_err, pin_err, bp_err;
    logic [DW-1:0] got, exp_rd;
    while (!req_ready) @(negedge clk);
    exp_addr  = a;
    addr_err  = 0;
    fight_err = 0;
    req_write = wr; req_addr = a; req_wdata = wd; req_be = be; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = $urandom;
    exp_rd = ref_read(a, be);
    if (wr) ref_write(a, wd, be);
    n = 1; n_setup = 0; n_hold = 0; n_strobe = 0; n_rsp = 0; n_hs = 0; n_ready = 0;
    seen = 0; rel_err = 0; pin_err = 0; bp_err = 0; hold_left = bp; got = '0;
    while (n < 500) begin
      if (!mem_cs_n && mem_ale_n && mem_addr == a) n_setup++;
      if (!mem_cs_n && !mem_ale_n && mem_addr == a) n_hold++;
      if (!mem_ale_n && mem_cs_n) begin
        if (mem_addr != '0) rel_err = 1;
        if (wr ? (mem_we_n || !mem_oe_n || !mem_dq_oe || mem_dq_out != wd)
               : (!mem_we_n || mem_oe_n || mem_dq_oe)) pin_err = 1;
        if (mem_be_n != ~be) pin_err = 1;
        n_strobe++;
      end else if (!mem_we_n || !mem_oe_n || mem_dq_oe || mem_be_n != 2'b11) pin_err = 1;
      if (rsp_valid && !seen) begin
        seen = 1; n_rsp = n; got = rsp_rdata;
      end
      if (seen && n_hs == 0) begin
        if (hold_left > 0) begin
          if (!rsp_valid || rsp_rdata != got || req_ready) bp_err = 1;
          hold_left--;
        end else begin
          rsp_ready = 1'b1;
          n_hs = n;
        end
      end
      if (req_ready) begin n_ready = n; break; end
      @(negedge clk);
      rsp_ready = 1'b0;
      n++;
    end
    chk(n_setup == TS, "R2", "setup cycles", n_setup, TS);
    chk(n_hold == TH, "R2", "latch hold cycles", n_hold, TH);
    chk(!rel_err && !addr_err, "R3", "address release / latched address", {rel_err, addr_err}, 0);
    chk(!fight_err, "R9", "bus contention", fight_err, 0);
    if (wr) begin
      chk(n_strobe == TST && !pin_err, "R4", "write strobe cycles", n_strobe, TST);
      chk(!seen, "R4", "no response for write", seen, 0);
      exp_ready = TS + TH + TST + TR + 1;
      chk(n_ready == exp_ready, "R7", "write recovery to ready", n_ready, exp_ready);
    end else begin
      chk(n_strobe == TST && !pin_err, "R5", "read strobe cycles", n_strobe, TST);
      chk(n_rsp == TS + TH + TST + 1, "R5", "read latency", n_rsp, TS + TH + TST + 1);
      chk(got == exp_rd, "R6", "read data with lane mask", got, exp_rd);
      chk(!bp_err, "R8", "response held under back-pressure", bp_err, 0);
      exp_ready = TS + TH + TST + TR + 1;
      if (n_hs + 1 > exp_ready) exp_ready = n_hs + 1;
      chk(n_ready == exp_ready, "R7", "read recovery to ready", n_ready, exp_ready);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [AW-1:0] pool [8];
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(mem_ale_n && mem_cs_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe
        && mem_addr == '0, "R1", "memory pins at reset",
        {mem_ale_n, mem_cs_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe}, 7'b1111110);
    chk(req_ready && !rsp_valid, "R1", "handshake at reset", {req_ready, rsp_valid}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) pool[i] = AW'($urandom);
    pool[0] = '1;
    pool[1] = '0;

    // directed: full write, lane-only writes, masked reads, empty-mask read
    run_txn(1, pool[0], 16'hBEEF, 2'b11, 0);
    run_txn(0, pool[0], '0, 2'b11, 0);       // R5 full word
    run_txn(1, pool[0], 16'h1234, 2'b01, 0); // R6 low lane only
    run_txn(0, pool[0], '0, 2'b11, 3);       // expect BE34, R8 hold 3
    run_txn(1, pool[0], 16'h5678, 2'b10, 0); // R6 high lane only
    run_txn(0, pool[0], '0, 2'b10, 0);       // upper lane, lower reads zero
    run_txn(0, pool[0], '0, 2'b01, 1);
    run_txn(0, pool[0], '0, 2'b00, 0);       // R6 no lanes -> zero
    run_txn(1, pool[1], 16'hFFFF, 2'b11, 0);
    run_txn(0, pool[1], '0, 2'b11, 7);

    // random mix
    for (int k = 0; k < 300; k++) begin
      run_txn(1'($urandom_range(0, 1)), pool[$urandom_range(0, 7)], DW'($urandom),
              2'($urandom), $urandom_range(0, 4));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule